// File: doc/BRIEF.md
# Vector register busy scoreboard

This block keeps the hazard state for one bank of physical vector registers that belongs to a single SIMD lane group. Each register carries two flags. A reservation flag marks a register that an issued instruction will write. A busy flag marks a register whose result is still being produced. The instruction front end asks whether every vector operand of a candidate instruction is free. It sends an issue command when a writer leaves the queue and an execute command when that writer enters a pipeline.

Arithmetic writers free their destination on their own. A countdown entry is loaded at execute, and its length depends on whether the operand is narrow (one register) or wide (two registers). Memory writers (loads, atomics and fences) skip the countdown and hold the register busy until an external completion pulse arrives. A wide operand covers its base register and the next one, wrapping from the last register back to register 0. When a readiness query is blocked, the block counts it as a read-after-write stall or as a stall on a destination, depending on the first blocking operand.

Top module: `vreg_hazard_tracker`

## Requirements
- R1: After reset every reservation flag and busy flag is 0, both stall counters are 0, and `timer_full` is 0.
- R2: A wide operand with base index i covers registers i and (i+1) mod NUM_REGS. A narrow operand covers register i only. This applies to issue, execute, release and query.
- R3: An issue command sets the reservation flag of every covered register on the next clock edge.
- R4: An execute command sets the busy flag and clears the reservation flag of every covered register on the next clock edge.
- R5: `ready` is 1 exactly when no valid operand covers a register whose reservation flag or busy flag is set. Operands with their valid bit at 0 are ignored.
- R6: A query with `query_en`=1 and `ready`=0 adds one to exactly one counter. The counter is `waw_stalls` if the lowest-numbered blocked operand is a destination (`op_dst`=1) and `raw_stalls` if it is a source. A query that is ready changes neither counter.
- R7: For an execute with `ex_mem`=0, the busy flags stay set for SP_DELAY clock cycles after the execute edge when the operand is narrow, and for DP_DELAY cycles when it is wide. They are then cleared.
- R8: For an execute with `ex_mem`=1, the busy flags stay set until a `rel_en` pulse names the same register and width. That pulse clears them on the next edge.
- R9: If a release (timed or external) and an execute hit the same register in one cycle, the register ends up busy.
- R10: `timer_full` is 1 exactly while QUEUE_DEPTH timed releases are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_en | input | 1 | Issue command: reserve a destination |
| iss_idx | input | IDX_W | Issue base register |
| iss_wide | input | 1 | Issue operand covers two registers |
| ex_en | input | 1 | Execute command: mark destination busy |
| ex_idx | input | IDX_W | Execute base register |
| ex_wide | input | 1 | Execute operand covers two registers |
| ex_mem | input | 1 | Memory writer: no timed release |
| rel_en | input | 1 | External completion for a memory writer |
| rel_idx | input | IDX_W | Completion base register |
| rel_wide | input | 1 | Completion operand covers two registers |
| query_en | input | 1 | Query is a real attempt (counts stalls) |
| op_valid | input | NUM_OPS | Operand slot holds a vector register |
| op_dst | input | NUM_OPS | Operand slot is a destination |
| op_wide | input | NUM_OPS | Operand slot covers two registers |
| op_idx | input | NUM_OPS*IDX_W | Base register per slot, slot 0 in the low bits |
| ready | output | 1 | All valid operands are free |
| rsv_flags | output | NUM_REGS | Reservation flag per register |
| busy_flags | output | NUM_REGS | Busy flag per register |
| raw_stalls | output | CNT_W | Blocked queries caused by a source operand |
| waw_stalls | output | CNT_W | Blocked queries caused by a destination operand |
| timer_full | output | 1 | No free countdown entry |

## Verification
The bench places a wide reservation across the wrap from the last register to register 0. A coverage function that fails to wrap would then leave register 0 free and report ready. Mixed operand lists check that the first blocked operand picks the counter; a scan that used the last blocked operand would bump the wrong counter. A timed release is timed against an execute of the same register in the same cycle, where a clear-over-set priority would drop the new writer. The countdown is also timed for both widths, where an off-by-one frees the register a cycle early or late.

// File: rtl/vrh_cover.sv
module vrh_cover #(
   parameter int NUM_REGS = 16,
   localparam int IDX_W = $clog2(NUM_REGS)
) (
   input  logic [IDX_W-1:0]    idx,
   input  logic                wide,
   output logic [NUM_REGS-1:0] mask
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_REGS - 1);
   logic [IDX_W-1:0] nxt;

   always_comb begin
      nxt = (idx == LAST) ? '0 : idx + 1'b1;
      mask = '0;
      mask[idx] = 1'b1;
      if (wide) mask[nxt] = 1'b1;
   end
endmodule

// File: rtl/vrh_flag_bank.sv
module vrh_flag_bank #(
   parameter int NUM_REGS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_REGS-1:0] set_rsv,
   input  logic [NUM_REGS-1:0] clr_rsv,
   input  logic [NUM_REGS-1:0] set_busy,
   input  logic [NUM_REGS-1:0] clr_busy,
   output logic [NUM_REGS-1:0] rsv,
   output logic [NUM_REGS-1:0] busy
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsv  <= '0;
         busy <= '0;
      end else begin
         rsv  <= (rsv & ~clr_rsv) | set_rsv;
         busy <= (busy & ~clr_busy) | set_busy;
      end
   end

   // R9: a set always lands, even against a clear in the same cycle
   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (set_busy != '0) |=> ((busy & $past(set_busy)) == $past(set_busy)));

   // R4: a clear without a matching set empties the reservation flag
   p_rsv_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_rsv & ~set_rsv) != '0) |=> ((rsv & $past(clr_rsv & ~set_rsv)) == '0));
endmodule

// File: rtl/vrh_release_timer.sv
module vrh_release_timer #(
   parameter int NUM_REGS    = 16,
   parameter int QUEUE_DEPTH = 4,
   parameter int SP_DELAY    = 3,
   parameter int DP_DELAY    = 6,
   localparam int IDX_W  = $clog2(NUM_REGS),
   localparam int MAXD   = (SP_DELAY > DP_DELAY) ? SP_DELAY : DP_DELAY,
   localparam int TCNT_W = $clog2(MAXD + 1),
   localparam int SLOT_W = (QUEUE_DEPTH > 1) ? $clog2(QUEUE_DEPTH) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                push,
   input  logic [IDX_W-1:0]    push_idx,
   input  logic                push_wide,
   output logic [NUM_REGS-1:0] rel_mask,
   output logic                full
);
   logic [QUEUE_DEPTH-1:0]  ent_vld;
   logic [IDX_W-1:0]        ent_idx  [QUEUE_DEPTH];
   logic                    ent_wide [QUEUE_DEPTH];
   logic [TCNT_W-1:0]       ent_cnt  [QUEUE_DEPTH];
   logic [QUEUE_DEPTH-1:0]  expire;
   logic [NUM_REGS-1:0]     ent_mask [QUEUE_DEPTH];
   logic [SLOT_W-1:0]       free_slot;
   logic                    have_free;
   logic [TCNT_W-1:0]       load_cnt;

   for (genvar e = 0; e < QUEUE_DEPTH; e++) begin : g_ent
      assign expire[e] = ent_vld[e] && (ent_cnt[e] == '0);
      vrh_cover #(.NUM_REGS(NUM_REGS)) u_cov (
         .idx (ent_idx[e]),
         .wide(ent_wide[e]),
         .mask(ent_mask[e])
      );
   end

   always_comb begin
      rel_mask = '0;
      for (int e = 0; e < QUEUE_DEPTH; e++)
         if (expire[e]) rel_mask = rel_mask | ent_mask[e];
   end

   always_comb begin
      free_slot = '0;
      have_free = 1'b0;
      for (int e = QUEUE_DEPTH - 1; e >= 0; e--)
         if (!ent_vld[e]) begin
            free_slot = SLOT_W'(e);
            have_free = 1'b1;
         end
   end

   assign full     = &ent_vld;
   assign load_cnt = push_wide ? TCNT_W'(DP_DELAY - 1) : TCNT_W'(SP_DELAY - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_vld <= '0;
         for (int e = 0; e < QUEUE_DEPTH; e++) begin
            ent_idx[e]  <= '0;
            ent_wide[e] <= 1'b0;
            ent_cnt[e]  <= '0;
         end
      end else begin
         for (int e = 0; e < QUEUE_DEPTH; e++) begin
            if (expire[e])       ent_vld[e] <= 1'b0;
            else if (ent_vld[e]) ent_cnt[e] <= ent_cnt[e] - 1'b1;
            if (push && have_free && (free_slot == SLOT_W'(e))) begin
               ent_vld[e]  <= 1'b1;
               ent_idx[e]  <= push_idx;
               ent_wide[e] <= push_wide;
               ent_cnt[e]  <= load_cnt;
            end
         end
      end
   end

   // R7: an entry whose count is exhausted leaves the queue on the next edge
   for (genvar e = 0; e < QUEUE_DEPTH; e++) begin : g_chk
      p_expire_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (ent_vld[e] && ent_cnt[e] == '0) |=> !ent_vld[e]);
   end
endmodule

// File: rtl/vrh_operand_check.sv
module vrh_operand_check #(
   parameter int NUM_REGS = 16,
   parameter int NUM_OPS  = 3,
   localparam int IDX_W = $clog2(NUM_REGS)
) (
   input  logic [NUM_OPS-1:0]       op_valid,
   input  logic [NUM_OPS-1:0]       op_dst,
   input  logic [NUM_OPS-1:0]       op_wide,
   input  logic [NUM_OPS*IDX_W-1:0] op_idx,
   input  logic [NUM_REGS-1:0]      rsv,
   input  logic [NUM_REGS-1:0]      busy,
   output logic                     ready,
   output logic                     first_is_dst
);
   logic [NUM_REGS-1:0] op_mask [NUM_OPS];
   logic [NUM_OPS-1:0]  blocked;
   logic [NUM_REGS-1:0] taken;

   assign taken = rsv | busy;

   for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
      vrh_cover #(.NUM_REGS(NUM_REGS)) u_cov (
         .idx (op_idx[i*IDX_W +: IDX_W]),
         .wide(op_wide[i]),
         .mask(op_mask[i])
      );
      assign blocked[i] = op_valid[i] && ((op_mask[i] & taken) != '0);
   end

   always_comb begin
      first_is_dst = 1'b0;
      for (int i = NUM_OPS - 1; i >= 0; i--)
         if (blocked[i]) first_is_dst = op_dst[i];
   end

   assign ready = (blocked == '0);
endmodule

// File: rtl/vreg_hazard_tracker.sv
module vreg_hazard_tracker #(
   parameter int NUM_REGS    = 16,
   parameter int GRANULE     = 4,
   parameter int NUM_OPS     = 3,
   parameter int SP_DELAY    = 3,
   parameter int DP_DELAY    = 6,
   parameter int QUEUE_DEPTH = 4,
   parameter int CNT_W       = 16,
   localparam int IDX_W = $clog2(NUM_REGS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     iss_en,
   input  logic [IDX_W-1:0]         iss_idx,
   input  logic                     iss_wide,
   input  logic                     ex_en,
   input  logic [IDX_W-1:0]         ex_idx,
   input  logic                     ex_wide,
   input  logic                     ex_mem,
   input  logic                     rel_en,
   input  logic [IDX_W-1:0]         rel_idx,
   input  logic                     rel_wide,
   input  logic                     query_en,
   input  logic [NUM_OPS-1:0]       op_valid,
   input  logic [NUM_OPS-1:0]       op_dst,
   input  logic [NUM_OPS-1:0]       op_wide,
   input  logic [NUM_OPS*IDX_W-1:0] op_idx,
   output logic                     ready,
   output logic [NUM_REGS-1:0]      rsv_flags,
   output logic [NUM_REGS-1:0]      busy_flags,
   output logic [CNT_W-1:0]         raw_stalls,
   output logic [CNT_W-1:0]         waw_stalls,
   output logic                     timer_full
);
   if (NUM_REGS % 2 != 0) begin : g_bad_odd
      $error("register count must be even");
   end
   if (NUM_REGS % GRANULE != 0) begin : g_bad_gran
      $error("register count must be a multiple of the allocation granule");
   end
   if (SP_DELAY < 1 || DP_DELAY < 1) begin : g_bad_delay
      $error("release delays must be at least one cycle");
   end

   logic [NUM_REGS-1:0] iss_mask, ex_mask, ext_mask, tmr_mask;
   logic [NUM_REGS-1:0] set_rsv, clr_rsv, set_busy, clr_busy;
   logic                first_is_dst;
   logic                timed_push;

   vrh_cover #(.NUM_REGS(NUM_REGS)) u_cov_iss (
      .idx(iss_idx), .wide(iss_wide), .mask(iss_mask));
   vrh_cover #(.NUM_REGS(NUM_REGS)) u_cov_ex (
      .idx(ex_idx), .wide(ex_wide), .mask(ex_mask));
   vrh_cover #(.NUM_REGS(NUM_REGS)) u_cov_rel (
      .idx(rel_idx), .wide(rel_wide), .mask(ext_mask));

   assign timed_push = ex_en && !ex_mem;
   assign set_rsv    = iss_en ? iss_mask : '0;
   assign clr_rsv    = ex_en  ? ex_mask  : '0;
   assign set_busy   = ex_en  ? ex_mask  : '0;
   assign clr_busy   = (rel_en ? ext_mask : '0) | tmr_mask;

   vrh_flag_bank #(.NUM_REGS(NUM_REGS)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_rsv (set_rsv),
      .clr_rsv (clr_rsv),
      .set_busy(set_busy),
      .clr_busy(clr_busy),
      .rsv     (rsv_flags),
      .busy    (busy_flags)
   );

   vrh_release_timer #(
      .NUM_REGS   (NUM_REGS),
      .QUEUE_DEPTH(QUEUE_DEPTH),
      .SP_DELAY   (SP_DELAY),
      .DP_DELAY   (DP_DELAY)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (timed_push),
      .push_idx (ex_idx),
      .push_wide(ex_wide),
      .rel_mask (tmr_mask),
      .full     (timer_full)
   );

   vrh_operand_check #(.NUM_REGS(NUM_REGS), .NUM_OPS(NUM_OPS)) u_check (
      .op_valid    (op_valid),
      .op_dst      (op_dst),
      .op_wide     (op_wide),
      .op_idx      (op_idx),
      .rsv         (rsv_flags),
      .busy        (busy_flags),
      .ready       (ready),
      .first_is_dst(first_is_dst)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         raw_stalls <= '0;
         waw_stalls <= '0;
      end else if (query_en && !ready) begin
         if (first_is_dst) waw_stalls <= waw_stalls + 1'b1;
         else              raw_stalls <= raw_stalls + 1'b1;
      end
   end

   // R10: a timed release is never requested with the queue full
   p_push_room_r10: assert property (@(posedge clk) disable iff (!rst_n)
      timed_push |-> !timer_full);

   // R6: a ready query leaves both counters unchanged
   p_ready_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (query_en && ready) |=> ($stable(raw_stalls) && $stable(waw_stalls)));

   // R6: a blocked query moves exactly one counter
   p_one_counter_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (query_en && !ready) |=>
         (($past(raw_stalls) != raw_stalls) != ($past(waw_stalls) != waw_stalls)));

   // R4: an execute leaves its registers busy
   p_exec_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ex_en |=> ((busy_flags & $past(ex_mask)) == $past(ex_mask)));
endmodule

// File: tb/vreg_hazard_tracker_tb.sv
module vreg_hazard_tracker_tb;
   localparam int N   = 16;
   localparam int IW  = 4;
   localparam int NOP = 3;
   localparam int SPD = 3;
   localparam int DPD = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic iss_en = 0, iss_wide = 0, ex_en = 0, ex_wide = 0, ex_mem = 0;
   logic rel_en = 0, rel_wide = 0, query_en = 0;
   logic [IW-1:0] iss_idx = 0, ex_idx = 0, rel_idx = 0;
   logic [NOP-1:0] op_valid = 0, op_dst = 0, op_wide = 0;
   logic [NOP*IW-1:0] op_idx = 0;
   logic ready, timer_full;
   logic [N-1:0] rsv_flags, busy_flags;
   logic [15:0] raw_stalls, waw_stalls;

   int n_chk = 0, n_fail = 0;

   always #10 clk = ~clk;

   vreg_hazard_tracker u_dut (
      .clk(clk), .rst_n(rst_n),
      .iss_en(iss_en), .iss_idx(iss_idx), .iss_wide(iss_wide),
      .ex_en(ex_en), .ex_idx(ex_idx), .ex_wide(ex_wide), .ex_mem(ex_mem),
      .rel_en(rel_en), .rel_idx(rel_idx), .rel_wide(rel_wide),
      .query_en(query_en), .op_valid(op_valid), .op_dst(op_dst),
      .op_wide(op_wide), .op_idx(op_idx), .ready(ready),
      .rsv_flags(rsv_flags), .busy_flags(busy_flags),
      .raw_stalls(raw_stalls), .waw_stalls(waw_stalls),
      .timer_full(timer_full)
   );

   function automatic logic [N-1:0] cov(input int idx, input bit wide);
      logic [N-1:0] m = '0;
      m[idx] = 1'b1;
      if (wide) m[(idx + 1) % N] = 1'b1;
      return m;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one clock: inputs held from the previous negedge, sampled at next negedge
   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_issue(input int idx, input bit wide);
      iss_en = 1; iss_idx = IW'(idx); iss_wide = wide;
      tick();
      iss_en = 0;
   endtask

   task automatic do_exec(input int idx, input bit wide, input bit mem);
      ex_en = 1; ex_idx = IW'(idx); ex_wide = wide; ex_mem = mem;
      tick();
      ex_en = 0; ex_mem = 0;
   endtask

   // per vector: {op2,op1,op0 each {valid,dst,wide,idx[3:0]}, ready, raw_inc, waw_inc}
   localparam int NV = 8;
   localparam logic [23:0] VEC [NV] = '{
      {7'd0, 7'd0, {3'b100, 4'd7}, 3'b100},
      {7'd0, 7'd0, {3'b100, 4'd3}, 3'b010},
      {7'd0, 7'd0, {3'b110, 4'd0}, 3'b001},
      {7'd0, 7'd0, {3'b101, 4'd14}, 3'b010},
      {7'd0, 7'd0, {3'b101, 4'd2}, 3'b010},
      {{3'b100, 4'd0}, {3'b110, 4'd3}, {3'b100, 4'd1}, 3'b001},
      {7'd0, {3'b100, 4'd8}, {3'b000, 4'd3}, 3'b100},
      {7'd0, {3'b100, 4'd3}, {3'b111, 4'd4}, 3'b010}
   };

   initial begin
      #3_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [N-1:0] exp_rsv, exp_busy;
      @(negedge clk);
      tick();
      // R1: reset state
      chk("R1 rsv", rsv_flags, 0);
      chk("R1 busy", busy_flags, 0);
      chk("R1 raw", raw_stalls, 0);
      chk("R1 waw", waw_stalls, 0);
      chk("R1 full", timer_full, 0);
      rst_n = 1;
      tick();

      // R3: narrow issue
      do_issue(3, 0);
      chk("R3 narrow issue", rsv_flags, cov(3, 0));
      // R2 R3: wide issue wraps from 15 to 0
      do_issue(15, 1);
      exp_rsv = cov(3, 0) | (1 << 15) | 1;
      chk("R2 wrap issue", rsv_flags, exp_rsv);
      // R4: memory execute of reg 3
      do_exec(3, 0, 1);
      exp_rsv = (1 << 15) | 1;
      chk("R4 rsv cleared", rsv_flags, exp_rsv);
      chk("R4 busy set", busy_flags, cov(3, 0));
      for (int k = 0; k < 10; k++) tick();
      chk("R8 mem still busy", busy_flags, cov(3, 0));

      // R5 R6: query table
      for (int v = 0; v < NV; v++) begin
         logic [15:0] r0, w0;
         for (int o = 0; o < NOP; o++) begin
            op_valid[o] = VEC[v][3 + o*7 + 6];
            op_dst[o]   = VEC[v][3 + o*7 + 5];
            op_wide[o]  = VEC[v][3 + o*7 + 4];
            op_idx[o*IW +: IW] = VEC[v][3 + o*7 +: 4];
         end
         query_en = 1;
         #1;
         chk($sformatf("R5 ready vec %0d", v), ready, VEC[v][2]);
         r0 = raw_stalls; w0 = waw_stalls;
         tick();
         query_en = 0;
         chk($sformatf("R6 raw vec %0d", v), raw_stalls - r0, VEC[v][1]);
         chk($sformatf("R6 waw vec %0d", v), waw_stalls - w0, VEC[v][0]);
      end
      op_valid = 0;

      // R8: external completion frees reg 3
      rel_en = 1; rel_idx = 3; rel_wide = 0;
      tick();
      rel_en = 0;
      chk("R8 release", busy_flags, 0);

      // R7: narrow timed release
      do_exec(9, 0, 0);
      tick(); tick();
      chk("R7 narrow held", busy_flags, cov(9, 0));
      tick();
      chk("R7 narrow freed", busy_flags, 0);

      // R7 R2 R4: wide timed release across the wrap
      do_exec(15, 1, 0);
      chk("R4 wide rsv clr", rsv_flags, 0);
      chk("R2 wide busy", busy_flags, cov(15, 1));
      for (int k = 0; k < DPD - 1; k++) tick();
      chk("R7 wide held", busy_flags, cov(15, 1));
      tick();
      chk("R7 wide freed", busy_flags, 0);

      // R9: new execute on the release edge
      do_exec(6, 0, 0);
      tick(); tick();
      do_exec(6, 0, 0);
      chk("R9 timed vs set", busy_flags, cov(6, 0));
      tick(); tick();
      chk("R9 second held", busy_flags, cov(6, 0));
      tick();
      chk("R9 second freed", busy_flags, 0);
      // R9: external release vs execute same cycle
      do_exec(5, 0, 1);
      rel_en = 1; rel_idx = 5; rel_wide = 0;
      ex_en = 1; ex_idx = 5; ex_wide = 0; ex_mem = 1;
      tick();
      rel_en = 0; ex_en = 0; ex_mem = 0;
      chk("R9 ext vs set", busy_flags, cov(5, 0));
      rel_en = 1; tick(); rel_en = 0;

      // R10: fill the countdown queue
      do_exec(8, 1, 0);
      do_exec(10, 1, 0);
      do_exec(12, 1, 0);
      chk("R10 not full", timer_full, 0);
      do_exec(0, 1, 0);
      chk("R10 full", timer_full, 1);
      for (int k = 0; k < DPD + 2; k++) tick();
      chk("R10 drained", timer_full, 0);
      chk("R7 all freed", busy_flags, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule